// File: doc/BRIEF.md
# Flag Offset Register Port

This block holds the two thresholds that a FIFO's partial-status flags compare against: the almost-empty offset `n` and the almost-full offset `m`. Each offset is split into a low register, as wide as the data bus, and a high register that carries the remaining upper bits the FIFO depth needs. All four registers are reached through the FIFO's own data buses, one register per clock edge. A rotating selector picks the register, so no address pins are needed.

One control input has two roles. Its level during reset fixes the role until the next reset. If it is held high, it acts as a second write enable for FIFO data. If it is held low, it becomes a load strobe. With the load strobe low, write-clock edges that have the primary write enable active store the input bus into the offset registers. Read-clock edges that have both read enables active copy the registers onto a registered output bus. Writes and reads each step through the same four-position sequence, and each keeps its own selector. The assembled offsets feed the FIFO flag logic. The block also gates the FIFO's push and pop requests so that offset traffic never moves FIFO data.

Top module: `flag_offset_port`

## Requirements
- R1: While `rst_n` is low, `wr_aux` is sampled on each write-clock edge. If it was high, `ofs_load_mode` reads 0 after reset and `wr_aux` acts as a second write enable. If it was low, `ofs_load_mode` reads 1 and `wr_aux` is an active-low load strobe.
- R2: In load mode, each write-clock edge with `wr_aux` low and `wr_en_n` low stores `cfg_din` into the next register in this fixed order: almost-empty low (position 0), almost-empty high (1), almost-full low (2), almost-full high (3). `almost_empty_ofs` = {empty high, empty low}, and `almost_full_ofs` = {full high, full low}. Each low register sits in bits [8:0]. An offset output changes in the edge that completes the write to its register.
- R3: After position 3, the next qualified write edge wraps around and writes the almost-empty low register again.
- R4: Edges without a qualified access leave the selector where it is. A load may stop after any subset of registers, and the next qualified access continues at the following position. The write and read selectors move independently.
- R5: In load mode, each read-clock edge with `wr_aux` low and both `rd_en_a_n` and `rd_en_b_n` low loads `cfg_dout` with the register at the read selector, in the same order as R2. `cfg_dout` holds its value on every other edge.
- R6: Reset sets both offsets to 7 (low register 7, high register 0). It returns both selectors to position 0 and clears `cfg_dout` to 0.
- R7: A high register is HI_W = max(DEPTH_LOG2 − 9, 0) bits wide; the default is 5. Writing it stores only `cfg_din[HI_W-1:0]`. Reading it returns that field with zeros above.
- R8: `fifo_push` = `wr_en_n` low and `wr_aux` high. `fifo_pop` = both read enables low, and in load mode also `wr_aux` high. Both are 0 during reset. In enable mode the offset registers are never written.
- R9: A qualified offset write and a qualified offset read never fall in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled on both clocks |
| wr_en_n | input | 1 | Primary write enable, active low |
| wr_aux | input | 1 | Dual-role input: second write enable (high) or load strobe (low) |
| rd_en_a_n | input | 1 | First read enable, active low |
| rd_en_b_n | input | 1 | Second read enable, active low |
| cfg_din | input | 9 | Input data bus |
| cfg_dout | output | 9 | Registered offset read-back value |
| ofs_load_mode | output | 1 | 1 when `wr_aux` was latched as a load strobe |
| fifo_push | output | 1 | Qualified FIFO data write request |
| fifo_pop | output | 1 | Qualified FIFO data read request |
| almost_empty_ofs | output | 14 | Assembled almost-empty offset n |
| almost_full_ofs | output | 14 | Assembled almost-full offset m |

## Verification
The assertions assume that the caller never requests an offset write and an offset read in the same cycle. The R9 property checks this, and every scenario task does one offset access per cycle and then returns to idle. The assertions also assume that `wr_aux` is steady around the last reset edge and that both clocks are one net. The bench drives the same clock into both clock ports. All inputs change on the falling edge, so every qualified access is seen cleanly at the next rising edge.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
   // Selector positions; the numeric order is the access sequence.
   typedef enum logic [1:0] {
      SEL_AE_LO = 2'd0,
      SEL_AE_HI = 2'd1,
      SEL_AF_LO = 2'd2,
      SEL_AF_HI = 2'd3
   } ofs_sel_e;

   function automatic ofs_sel_e ofs_sel_next(input ofs_sel_e s);
      case (s)
         SEL_AE_LO: return SEL_AE_HI;
         SEL_AE_HI: return SEL_AF_LO;
         SEL_AF_LO: return SEL_AF_HI;
         default:   return SEL_AE_LO;
      endcase
   endfunction
endpackage

// File: rtl/ofs_sel_seq.sv
module ofs_sel_seq
   import ofs_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     adv,
   output ofs_sel_e sel
);
   ofs_sel_e sel_q;

   always_ff @(posedge clk) begin
      if (!rst_n)   sel_q <= SEL_AE_LO;
      else if (adv) sel_q <= ofs_sel_next(sel_q);
   end

   assign sel = sel_q;

   // R4: the position persists across idle edges
   assert_sel_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(sel));
   // R2 / R3: every access moves the selector
   assert_sel_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> sel != $past(sel));
endmodule

// File: rtl/ofs_bank.sv
module ofs_bank
   import ofs_pkg::*;
#(
   parameter int LO_W    = 9,
   parameter int HI_W    = 5,
   parameter int DEF_LO  = 7,
   localparam int OFS_W  = LO_W + HI_W
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  ofs_sel_e         sel,
   input  logic [LO_W-1:0]  din,
   output logic [OFS_W-1:0] ae_ofs,
   output logic [OFS_W-1:0] af_ofs,
   output logic [LO_W-1:0]  rv_ae_lo,
   output logic [LO_W-1:0]  rv_ae_hi,
   output logic [LO_W-1:0]  rv_af_lo,
   output logic [LO_W-1:0]  rv_af_hi
);
   logic [LO_W-1:0] ae_lo_q, af_lo_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ae_lo_q <= LO_W'(DEF_LO);
         af_lo_q <= LO_W'(DEF_LO);
      end else if (we) begin
         if (sel == SEL_AE_LO) ae_lo_q <= din;
         if (sel == SEL_AF_LO) af_lo_q <= din;
      end
   end

   assign rv_ae_lo = ae_lo_q;
   assign rv_af_lo = af_lo_q;

   generate
      if (HI_W > 0) begin : g_hi
         logic [HI_W-1:0] ae_hi_q, af_hi_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ae_hi_q <= '0;
               af_hi_q <= '0;
            end else if (we) begin
               if (sel == SEL_AE_HI) ae_hi_q <= din[HI_W-1:0];
               if (sel == SEL_AF_HI) af_hi_q <= din[HI_W-1:0];
            end
         end
         assign ae_ofs   = {ae_hi_q, ae_lo_q};
         assign af_ofs   = {af_hi_q, af_lo_q};
         assign rv_ae_hi = LO_W'(ae_hi_q);
         assign rv_af_hi = LO_W'(af_hi_q);
      end else begin : g_nohi
         assign ae_ofs   = ae_lo_q;
         assign af_ofs   = af_lo_q;
         assign rv_ae_hi = '0;
         assign rv_af_hi = '0;
      end
   endgenerate

   // R2: an offset moves only when one of its own registers is written
   assert_ae_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && (sel == SEL_AE_LO || sel == SEL_AE_HI)) |=> $stable(ae_ofs));
   assert_af_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && (sel == SEL_AF_LO || sel == SEL_AF_HI)) |=> $stable(af_ofs));
endmodule

// File: rtl/ofs_rdport.sv
module ofs_rdport
   import ofs_pkg::*;
#(
   parameter int LO_W = 9,
   parameter int HI_W = 5
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            re,
   input  ofs_sel_e        sel,
   input  logic [LO_W-1:0] rv_ae_lo,
   input  logic [LO_W-1:0] rv_ae_hi,
   input  logic [LO_W-1:0] rv_af_lo,
   input  logic [LO_W-1:0] rv_af_hi,
   output logic [LO_W-1:0] dout
);
   logic [LO_W-1:0] pick;
   logic [LO_W-1:0] dout_q;

   always_comb begin
      case (sel)
         SEL_AE_LO: pick = rv_ae_lo;
         SEL_AE_HI: pick = rv_ae_hi;
         SEL_AF_LO: pick = rv_af_lo;
         default:   pick = rv_af_hi;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  dout_q <= '0;
      else if (re) dout_q <= pick;
   end

   assign dout = dout_q;

   // R5: the output register moves only on a qualified read
   assert_dout_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !re |=> $stable(dout));

   generate
      if (HI_W < LO_W) begin : g_zchk
         // R7: high-register read-back has zeros above its width
         assert_hi_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
            re && (sel == SEL_AE_HI || sel == SEL_AF_HI)
            |=> dout[LO_W-1:HI_W] == '0);
      end
   endgenerate
endmodule

// File: rtl/flag_offset_port.sv
module flag_offset_port
   import ofs_pkg::*;
#(
   parameter int LO_W       = 9,
   parameter int DEPTH_LOG2 = 14,
   parameter int DEF_LO     = 7,
   localparam int HI_W  = (DEPTH_LOG2 > LO_W) ? DEPTH_LOG2 - LO_W : 0,
   localparam int OFS_W = LO_W + HI_W
)(
   input  logic             wclk,
   input  logic             rclk,
   input  logic             rst_n,
   input  logic             wr_en_n,
   input  logic             wr_aux,
   input  logic             rd_en_a_n,
   input  logic             rd_en_b_n,
   input  logic [LO_W-1:0]  cfg_din,
   output logic [LO_W-1:0]  cfg_dout,
   output logic             ofs_load_mode,
   output logic             fifo_push,
   output logic             fifo_pop,
   output logic [OFS_W-1:0] almost_empty_ofs,
   output logic [OFS_W-1:0] almost_full_ofs
);
   generate
      if (HI_W > LO_W) begin : g_bad_depth
         $error("flag_offset_port: DEPTH_LOG2 needs a high register wider than the bus");
      end
      if (DEF_LO >= (1 << LO_W)) begin : g_bad_default
         $error("flag_offset_port: DEF_LO does not fit the low register");
      end
   endgenerate

   logic     mode_q;
   logic     ofs_we, ofs_re, rd_both;
   ofs_sel_e wsel, rsel;
   logic [LO_W-1:0] rv_ae_lo, rv_ae_hi, rv_af_lo, rv_af_hi;

   // Role of wr_aux is captured only while reset is held
   always_ff @(posedge wclk) begin
      if (!rst_n) mode_q <= ~wr_aux;
   end

   assign ofs_load_mode = mode_q;
   assign rd_both   = ~rd_en_a_n & ~rd_en_b_n;
   assign ofs_we    = rst_n & mode_q & ~wr_aux & ~wr_en_n;
   assign ofs_re    = rst_n & mode_q & ~wr_aux & rd_both;
   assign fifo_push = rst_n & ~wr_en_n & wr_aux;
   assign fifo_pop  = rst_n & rd_both & (~mode_q | wr_aux);

   ofs_sel_seq u_wseq (.clk(wclk), .rst_n(rst_n), .adv(ofs_we), .sel(wsel));
   ofs_sel_seq u_rseq (.clk(rclk), .rst_n(rst_n), .adv(ofs_re), .sel(rsel));

   ofs_bank #(.LO_W(LO_W), .HI_W(HI_W), .DEF_LO(DEF_LO)) u_bank (
      .clk(wclk), .rst_n(rst_n), .we(ofs_we), .sel(wsel), .din(cfg_din),
      .ae_ofs(almost_empty_ofs), .af_ofs(almost_full_ofs),
      .rv_ae_lo(rv_ae_lo), .rv_ae_hi(rv_ae_hi),
      .rv_af_lo(rv_af_lo), .rv_af_hi(rv_af_hi)
   );

   ofs_rdport #(.LO_W(LO_W), .HI_W(HI_W)) u_rd (
      .clk(rclk), .rst_n(rst_n), .re(ofs_re), .sel(rsel),
      .rv_ae_lo(rv_ae_lo), .rv_ae_hi(rv_ae_hi),
      .rv_af_lo(rv_af_lo), .rv_af_hi(rv_af_hi), .dout(cfg_dout)
   );

   // R8: offset traffic never becomes a FIFO push or pop
   assert_no_push_in_load_R8: assert property (@(posedge wclk) disable iff (!rst_n)
      (ofs_load_mode && !wr_aux) |-> !fifo_push && !fifo_pop);
   // R8: in enable mode the offsets stay frozen
   assert_enable_frozen_R8: assert property (@(posedge wclk) disable iff (!rst_n)
      !ofs_load_mode |=> $stable(almost_empty_ofs) && $stable(almost_full_ofs));
   // R9: caller keeps offset writes and reads apart
   assert_no_collide_R9: assert property (@(posedge wclk) disable iff (!rst_n)
      !(ofs_we && ofs_re));
endmodule

// File: tb/sim_flag_offset_port.sv
module sim_flag_offset_port;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en_n = 1'b1, wr_aux = 1'b1, rd_en_a_n = 1'b1, rd_en_b_n = 1'b1;
   logic [8:0]  cfg_din = '0;
   logic [8:0]  cfg_dout;
   logic        ofs_load_mode, fifo_push, fifo_pop;
   logic [13:0] almost_empty_ofs, almost_full_ofs;
   int checks = 0, errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   flag_offset_port u0 (
      .wclk(clk), .rclk(clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .wr_aux(wr_aux),
      .rd_en_a_n(rd_en_a_n), .rd_en_b_n(rd_en_b_n), .cfg_din(cfg_din),
      .cfg_dout(cfg_dout), .ofs_load_mode(ofs_load_mode), .fifo_push(fifo_push),
      .fifo_pop(fifo_pop), .almost_empty_ofs(almost_empty_ofs),
      .almost_full_ofs(almost_full_ofs)
   );

   function automatic logic [13:0] mk(input logic [8:0] hi, input logic [8:0] lo);
      return {hi[4:0], lo};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic aux);
      @(negedge clk);
      rst_n = 1'b0; wr_aux = aux; wr_en_n = 1'b1; rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1; wr_aux = 1'b1;
   endtask

   task automatic ofs_write(input logic [8:0] v);
      @(negedge clk);
      wr_en_n = 1'b0; wr_aux = 1'b0; cfg_din = v;
      @(negedge clk);
      wr_en_n = 1'b1; wr_aux = 1'b1;
   endtask

   task automatic ofs_read(output logic [8:0] v);
      @(negedge clk);
      rd_en_a_n = 1'b0; rd_en_b_n = 1'b0; wr_aux = 1'b0;
      @(negedge clk);
      v = cfg_dout;
      rd_en_a_n = 1'b1; rd_en_b_n = 1'b1; wr_aux = 1'b1;
   endtask

   task automatic t_reset_defaults;
      do_reset(1'b0);
      chk("R1 load mode", ofs_load_mode, 1);
      chk("R6 ae default", almost_empty_ofs, 7);
      chk("R6 af default", almost_full_ofs, 7);
      chk("R6 dout cleared", cfg_dout, 0);
   endtask

   task automatic t_order_and_wrap;
      logic [8:0] v;
      do_reset(1'b0);
      ofs_write(9'h0A5);
      chk("R2 ae low first", almost_empty_ofs, mk(0, 9'h0A5));
      ofs_write(9'h003);
      ofs_write(9'h1C2);
      ofs_write(9'h011);
      chk("R2 ae assembled", almost_empty_ofs, mk(9'h003, 9'h0A5));
      chk("R2 af assembled", almost_full_ofs, mk(9'h011, 9'h1C2));
      ofs_read(v); chk("R5 read 0 ae lo", v, 9'h0A5);
      ofs_read(v); chk("R5 read 1 ae hi", v, 9'h003);
      ofs_read(v); chk("R5 read 2 af lo", v, 9'h1C2);
      ofs_read(v); chk("R5 read 3 af hi", v, 9'h011);
      ofs_read(v); chk("R3 read wraps", v, 9'h0A5);
      ofs_write(9'h055);
      chk("R3 fifth write ae lo", almost_empty_ofs, mk(9'h003, 9'h055));
      chk("R3 af untouched", almost_full_ofs, mk(9'h011, 9'h1C2));
      repeat (2) @(negedge clk);
      chk("R5 dout holds", cfg_dout, 9'h0A5);
   endtask

   task automatic t_pause_resume;
      logic [8:0] v;
      do_reset(1'b0);
      ofs_write(9'h010);
      @(negedge clk);
      wr_en_n = 1'b0; wr_aux = 1'b1; cfg_din = 9'h1FF;
      #1 chk("R8 push with strobe high", fifo_push, 1);
      repeat (3) @(negedge clk);
      wr_en_n = 1'b1;
      chk("R4 pause leaves ae", almost_empty_ofs, mk(0, 9'h010));
      ofs_write(9'h002);
      chk("R4 resume at ae hi", almost_empty_ofs, mk(9'h002, 9'h010));
      chk("R4 af untouched", almost_full_ofs, 7);
      ofs_read(v); chk("R4 read first", v, 9'h010);
      repeat (3) @(negedge clk);
      ofs_read(v); chk("R4 read resumes", v, 9'h002);
   endtask

   task automatic t_hi_mask;
      logic [8:0] v;
      do_reset(1'b0);
      ofs_write(9'h001);
      ofs_write(9'h1FF);
      chk("R7 upper bits dropped", almost_empty_ofs, 14'h3E01);
      ofs_read(v); chk("R7 read lo", v, 9'h001);
      ofs_read(v); chk("R7 hi reads zero-extended", v, 9'h01F);
   endtask

   task automatic t_load_gating;
      do_reset(1'b0);
      @(negedge clk);
      wr_en_n = 1'b0; wr_aux = 1'b0; cfg_din = 9'h020;
      #1 chk("R8 no push while loading", fifo_push, 0);
      @(negedge clk);
      wr_en_n = 1'b1; rd_en_a_n = 1'b0; rd_en_b_n = 1'b0;
      #1 chk("R8 no pop while loading", fifo_pop, 0);
      @(negedge clk);
      wr_aux = 1'b1;
      #1 chk("R8 pop with strobe high", fifo_pop, 1);
      @(negedge clk);
      rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
   endtask

   task automatic t_enable_mode;
      do_reset(1'b1);
      chk("R1 enable mode", ofs_load_mode, 0);
      @(negedge clk);
      wr_en_n = 1'b0; wr_aux = 1'b0; cfg_din = 9'h1AA;
      #1 chk("R8 second enable low blocks push", fifo_push, 0);
      @(negedge clk);
      chk("R8 offsets frozen ae", almost_empty_ofs, 7);
      chk("R8 offsets frozen af", almost_full_ofs, 7);
      wr_aux = 1'b1;
      #1 chk("R8 push in enable mode", fifo_push, 1);
      @(negedge clk);
      wr_en_n = 1'b1; wr_aux = 1'b0; rd_en_a_n = 1'b0; rd_en_b_n = 1'b0;
      #1 chk("R8 pop in enable mode", fifo_pop, 1);
      @(negedge clk);
      rd_en_a_n = 1'b1; rd_en_b_n = 1'b1; wr_aux = 1'b1;
      chk("R8 no offset read in enable mode", cfg_dout, 0);
   endtask

   initial begin
      t_reset_defaults();
      t_order_and_wrap();
      t_pause_resume();
      t_hi_mask();
      t_load_gating();
      t_enable_mode();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog R1..all act=hung exp=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule